// File: doc/BRIEF.md
# Multichannel Time-Binned Scaler

This block counts pulses on several independent inputs and splits the counts into consecutive time bins. A bin-advance strobe closes the open bin, writes one count word per channel into an output FIFO, and opens the next bin from zero. Software reads the words from the FIFO one at a time, lowest channel first. It may drain the FIFO during acquisition, using the fill level to avoid overflow.

An arm command prepares a run. It flushes the FIFO, clears the counters, the advance tally and the flags, and latches how many advances the run should take. Software normally sets this total to iterations times bins per iteration. When that total is reached the block stops on its own and sets a done flag. It then ignores further advances and pulses until the next arm. A gate input held low stops counting, for example during a dead interval between bins. Software can poll the advance tally or the done flag to detect the end of a run.

Top module: `tbin_scaler`

## Requirements
- R1: After reset the FIFO is empty (`empty_o`=1, `level_o`=0), and `adv_count_o`, `done_o` and `overflow_o` are all 0.
- R2: Each rising edge on a `hit_i` bit adds one to that channel's count. A pulse held high for many cycles counts once, and the channels count independently.
- R3: While `gate_i` is 0, rising edges on `hit_i` are not counted.
- R4: A rising edge on `adv_i` during a run pushes one word per channel into the FIFO, in the order channel 0, 1, 2, 3. Each word is that channel's count for the bin being closed. The counters then restart from zero.
- R5: A per-channel count saturates at all-ones (2^CNT_W-1) and does not wrap.
- R6: `adv_count_o` rises by one for each advance accepted since the last arm.
- R7: `done_o` is set when `adv_count_o` equals the armed preset. A preset of 0 sets it at arm. While done, advances push no words and leave `adv_count_o` unchanged.
- R8: An arm flushes the FIFO and clears the counters, `adv_count_o`, `done_o` and `overflow_o`.
- R9: If the FIFO has fewer free entries than channels when a bin closes, all of that bin's words are dropped. `overflow_o` is then set and stays set until the next arm.
- R10: `rd_data_o` shows the oldest word, and `rd_i` removes it, lowering `level_o` by one. A read of an empty FIFO changes nothing.
- R11: Before the first arm, pulses and advances have no effect: no words, and `adv_count_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Arm strobe, one cycle |
| preset_i | input | ADV_W | Total advances for the run, latched on arm |
| gate_i | input | 1 | Counting enable (1 = count) |
| hit_i | input | NCH | Asynchronous pulse inputs, one per channel |
| adv_i | input | 1 | Asynchronous bin-advance strobe |
| rd_i | input | 1 | Pop the oldest FIFO word |
| rd_data_o | output | CNT_W | Oldest FIFO word |
| empty_o | output | 1 | FIFO empty |
| level_o | output | $clog2(FIFO_DEPTH+1) | FIFO fill level in words |
| adv_count_o | output | ADV_W | Advances accepted since arm |
| done_o | output | 1 | Preset number of advances reached |
| overflow_o | output | 1 | Sticky: a bin was dropped for lack of room |

## Verification
The bench holds a pulse high for many cycles to catch a level-sensitive counter, which would report far more than one count. It fills the FIFO to exactly its depth and then closes one more bin. A design that wrote a partial bin would leave words out of order, and one that wrapped would overwrite old data. It sends advances after done, where a design that kept counting would push extra words or run the tally past the preset. It drives 300 pulses into an 8-bit counter, where a wrapping counter would report 44 instead of 255. It re-arms with counts pending, and a design that failed to clear them would leak them into the next bin.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } tbs_state_e;

  // true when n more words fit into a FIFO holding lvl of depth words
  function automatic logic fifo_room(input int unsigned lvl,
                                     input int unsigned depth,
                                     input int unsigned n);
    return (lvl + n) <= depth;
  endfunction
endpackage

// File: rtl/tbs_edge_sync.sv
module tbs_edge_sync #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] in_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= in_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~prev_q;

  // R2: a rise cannot repeat on the next cycle
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_chk
      single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o[g] |=> !rise_o[g]);
    end
  endgenerate
endmodule

// File: rtl/tbs_bin_counter.sv
module tbs_bin_counter #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          close_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] MAXV = '1;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v == MAXV) ? v : v + CW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) cnt_o <= '0;
    else if (close_i)    cnt_o <= inc_i ? CW'(1) : '0;
    else if (inc_i)      cnt_o <= sat_inc(cnt_o);
  end

  // R5
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == MAXV && !clr_i && !close_i) |=> cnt_o == MAXV);
endmodule

// File: rtl/tbs_word_fifo.sv
module tbs_word_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 16,
  parameter int NWR   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush_i,
  input  logic                          wr_i,
  input  logic [NWR*W-1:0]              wr_words_i,
  input  logic                          rd_i,
  output logic [W-1:0]                  rd_data_o,
  output logic [$clog2(DEPTH+1)-1:0]    level_o,
  output logic                          empty_o,
  output logic                          drop_o
);
  import tbs_pkg::*;
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [LW-1:0] cnt_q;
  logic          room, push, pop;

  assign room   = fifo_room(int'(cnt_q), DEPTH, NWR);
  assign push   = wr_i && room && !flush_i;
  assign pop    = rd_i && (cnt_q != '0) && !flush_i;
  assign drop_o = wr_i && !room && !flush_i;

  always_ff @(posedge clk) begin
    if (push) begin
      for (int i = 0; i < NWR; i++)
        mem[wp_q + AW'(i)] <= wr_words_i[i*W +: W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= wp_q + AW'(NWR);
      if (pop)  rp_q <= rp_q + AW'(1);
      cnt_q <= cnt_q + (push ? LW'(NWR) : '0) - (pop ? LW'(1) : '0);
    end
  end

  assign rd_data_o = mem[rp_q];
  assign level_o   = cnt_q;
  assign empty_o   = (cnt_q == '0);

  // R9
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_o <= LW'(DEPTH));
  // R9
  drop_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o |=> level_o <= $past(level_o));
endmodule

// File: rtl/tbin_scaler.sv
module tbin_scaler #(
  parameter int NCH        = 4,
  parameter int CNT_W      = 24,
  parameter int ADV_W      = 16,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             arm_i,
  input  logic [ADV_W-1:0]                 preset_i,
  input  logic                             gate_i,
  input  logic [NCH-1:0]                   hit_i,
  input  logic                             adv_i,
  input  logic                             rd_i,
  output logic [CNT_W-1:0]                 rd_data_o,
  output logic                             empty_o,
  output logic [$clog2(FIFO_DEPTH+1)-1:0]  level_o,
  output logic [ADV_W-1:0]                 adv_count_o,
  output logic                             done_o,
  output logic                             overflow_o
);
  import tbs_pkg::*;

  tbs_state_e          state_q;
  logic [ADV_W-1:0]    preset_q, adv_cnt_q;
  logic                ovf_q;
  logic [NCH:0]        rise;
  logic [NCH-1:0]      hit_rise;
  logic                adv_rise, running, adv_take, fifo_drop;
  logic [NCH*CNT_W-1:0] bin_words;

  tbs_edge_sync #(.N(NCH+1)) sync_i (
    .clk(clk), .rst_n(rst_n), .in_i({adv_i, hit_i}), .rise_o(rise));

  assign hit_rise = rise[NCH-1:0];
  assign adv_rise = rise[NCH];
  assign running  = (state_q == ST_RUN);
  assign adv_take = running && adv_rise && !arm_i;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      tbs_bin_counter #(.CW(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .clr_i(arm_i), .close_i(adv_take),
        .inc_i(running && gate_i && hit_rise[g]),
        .cnt_o(bin_words[g*CNT_W +: CNT_W]));
    end
  endgenerate

  tbs_word_fifo #(.W(CNT_W), .DEPTH(FIFO_DEPTH), .NWR(NCH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .flush_i(arm_i), .wr_i(adv_take),
    .wr_words_i(bin_words), .rd_i(rd_i), .rd_data_o(rd_data_o),
    .level_o(level_o), .empty_o(empty_o), .drop_o(fifo_drop));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      preset_q  <= '0;
      adv_cnt_q <= '0;
      ovf_q     <= 1'b0;
    end else if (arm_i) begin
      state_q   <= (preset_i == '0) ? ST_DONE : ST_RUN;
      preset_q  <= preset_i;
      adv_cnt_q <= '0;
      ovf_q     <= 1'b0;
    end else begin
      if (fifo_drop) ovf_q <= 1'b1;
      if (adv_take) begin
        adv_cnt_q <= adv_cnt_q + ADV_W'(1);
        if (adv_cnt_q + ADV_W'(1) == preset_q) state_q <= ST_DONE;
      end
    end
  end

  assign adv_count_o = adv_cnt_q;
  assign done_o      = (state_q == ST_DONE);
  assign overflow_o  = ovf_q;

  // R7
  done_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> adv_count_o == preset_q);
  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !arm_i) |=> $stable(adv_count_o) && done_o);
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow_o && !arm_i) |=> overflow_o);
  // R6
  adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_take |=> adv_count_o == $past(adv_count_o) + ADV_W'(1));
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (adv_count_o == '0 && empty_o));
endmodule

// File: tb/tbin_scaler_tb_top.sv
module tbin_scaler_tb_top;
  localparam int NCH = 4, CW = 8, AW = 16, DEPTH = 16;
  localparam int MAXC = (1 << CW) - 1;
  localparam int LW = $clog2(DEPTH+1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic arm = 1'b0, gate = 1'b1, adv = 1'b0, rd = 1'b0;
  logic [AW-1:0] preset = '0;
  logic [NCH-1:0] hit = '0;
  logic [CW-1:0] rd_data;
  logic empty, done, ovf;
  logic [LW-1:0] level;
  logic [AW-1:0] adv_count;

  always #4 clk = ~clk;

  tbin_scaler #(.NCH(NCH), .CNT_W(CW), .ADV_W(AW), .FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .preset_i(preset), .gate_i(gate),
    .hit_i(hit), .adv_i(adv), .rd_i(rd), .rd_data_o(rd_data), .empty_o(empty),
    .level_o(level), .adv_count_o(adv_count), .done_o(done), .overflow_o(ovf));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  // bench model
  int m_cnt [NCH];
  int m_q [$];
  int m_adv = 0, m_preset = 0;
  bit m_run = 0, m_done = 0, m_ovf = 0;

  function automatic int sat_add(int v);
    return (v >= MAXC) ? MAXC : v + 1;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic status(string req);
    check(int'(level) == m_q.size(), {req, " level"}, int'(level), m_q.size());
    check(int'(adv_count) == m_adv, {req, " adv_count"}, int'(adv_count), m_adv);
    check(done == m_done, {req, " done"}, int'(done), int'(m_done));
    check(ovf == m_ovf, {req, " overflow"}, int'(ovf), int'(m_ovf));
  endtask

  task automatic do_arm(int p);
    @(negedge clk); arm = 1'b1; preset = AW'(p);
    @(negedge clk); arm = 1'b0;
    for (int i = 0; i < NCH; i++) m_cnt[i] = 0;
    m_q.delete(); m_adv = 0; m_preset = p; m_ovf = 0;
    m_done = (p == 0); m_run = (p != 0);
  endtask

  task automatic pulse(logic [NCH-1:0] mask, int hold);
    @(negedge clk); hit = mask;
    repeat (hold) @(negedge clk);
    hit = '0;
    repeat (2) @(negedge clk);
    if (m_run && gate)
      for (int i = 0; i < NCH; i++) if (mask[i]) m_cnt[i] = sat_add(m_cnt[i]);
  endtask

  task automatic advance();
    @(negedge clk); adv = 1'b1;
    repeat (2) @(negedge clk);
    adv = 1'b0;
    repeat (2) @(negedge clk);
    if (m_run) begin
      if (m_q.size() + NCH <= DEPTH)
        for (int i = 0; i < NCH; i++) m_q.push_back(m_cnt[i]);
      else m_ovf = 1;
      for (int i = 0; i < NCH; i++) m_cnt[i] = 0;
      m_adv++;
      if (m_adv == m_preset) begin m_done = 1; m_run = 0; end
    end
  endtask

  task automatic drain(string req);
    while (m_q.size() > 0) begin
      check(int'(rd_data) == m_q[0], {req, " word"}, int'(rd_data), m_q[0]);
      rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
      void'(m_q.pop_front());
    end
    check(empty == 1'b1, {req, " empty after drain"}, int'(empty), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < NCH; i++) m_cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(empty == 1'b1, "R1 empty", int'(empty), 1);
    status("R1");

    // R11 nothing happens before the first arm
    pulse(4'hF, 2);
    advance();
    status("R11");

    // R2 R4 basic bin, long held pulse counts once
    do_arm(8);
    gate = 1'b1;
    pulse(4'b0001, 2);
    pulse(4'b0011, 2);
    pulse(4'b1111, 40);
    advance();
    status("R4");
    check(m_q[0] == 3 && m_q[3] == 1, "R2 model", m_q[0], 3);
    drain("R2 R4");

    // R3 gate low inhibits
    gate = 1'b0;
    pulse(4'b1111, 2);
    pulse(4'b1111, 2);
    gate = 1'b1;
    pulse(4'b0100, 2);
    advance();
    drain("R3");

    // R10 read of empty FIFO ignored
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    check(int'(level) == 0, "R10 empty read level", int'(level), 0);
    status("R10");

    // R8 arm clears pending counts
    pulse(4'b1010, 2);
    do_arm(4);
    status("R8 after arm");
    advance();
    drain("R8 counters cleared");

    // R9 overflow
    do_arm(10);
    for (int b = 0; b < 5; b++) begin
      for (int k = 0; k <= b; k++) pulse(4'(b + 1), 2);
      advance();
    end
    status("R9");
    check(ovf == 1'b1, "R9 overflow set", int'(ovf), 1);
    advance();
    check(ovf == 1'b1, "R9 overflow sticky", int'(ovf), 1);
    drain("R9");
    do_arm(5);
    check(ovf == 1'b0, "R8 overflow cleared", int'(ovf), 0);

    // R7 done and later advances ignored
    do_arm(3);
    for (int b = 0; b < 3; b++) begin
      pulse(4'b1001, 2);
      advance();
    end
    status("R7 done");
    pulse(4'hF, 2);
    advance();
    status("R7 ignored");
    drain("R7");
    do_arm(0);
    check(done == 1'b1, "R7 zero preset", int'(done), 1);

    // R5 saturation
    do_arm(2);
    for (int k = 0; k < 300; k++) pulse(4'b0100, 1);
    advance();
    check(m_q[2] == MAXC, "R5 model", m_q[2], MAXC);
    drain("R5");

    // R6 R2 R3 random bins
    do_arm(30);
    for (int b = 0; b < 30; b++) begin
      int np;
      gate = ($urandom_range(0, 3) != 0);
      np = $urandom_range(0, 5);
      for (int k = 0; k < np; k++) pulse(4'($urandom_range(0, 15)), $urandom_range(1, 4));
      gate = 1'b1;
      if ($urandom_range(0, 1) == 1) pulse(4'($urandom_range(0, 15)), 2);
      advance();
      status("R6 random");
      drain("R2 R3 random");
    end
    check(done == 1'b1, "R6 random done", int'(done), 1);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule